// File: doc/BRIEF.md
# Context-tagged translation lookaside buffer

A small fully associative translation buffer for 4 KiB pages. Every entry is tagged with a 12-bit context number, so translations from several address spaces can sit in the array together and no flush is needed on a context switch. The tag is built from the page-aligned virtual address with the context number placed in its twelve low bits, which are zero after page alignment. Lookups and fills build the tag the same way from the control-register state present in that cycle: a context-enable bit and the low twelve bits of the page-table base register.

A lookup is registered. Its result (hit, physical address, read-only and uncacheable flags) appears one cycle after the request. A page walker fills the array through a separate port. A fill for a tag already present leaves that entry as it is. Otherwise the fill takes the lowest-numbered free slot, or, when every slot is valid, evicts the least recently used entry. Each fill and each lookup hit gives the entry a fresh sequence stamp. A flush input clears every valid bit.

Top module: `pcid_tlb`

## Requirements
- R1: After a synchronous reset `rsp_valid` is 0 and every lookup misses.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid` high, and 0 otherwise. `rsp_hit` is only 1 while `rsp_valid` is 1.
- R3: On a hit, `rsp_paddr` is the stored 20-bit physical page in bits 31:12 with the request's bits 11:0 below it. `rsp_ro` and `rsp_uc` return the stored flags. On a miss all three are 0.
- R4: The context number is `ptbase_low` when `ctx_en` is 1 and 0 when `ctx_en` is 0. With `ctx_en` at 0, `ptbase_low` has no effect.
- R5: The same virtual page filled under two different context numbers occupies two entries. A lookup returns the entry whose context matches.
- R6: A fill whose tag is already present allocates nothing and leaves that entry's physical page, flags and stamp unchanged.
- R7: While any slot is invalid, a fill of a new tag evicts no valid entry.
- R8: When all slots are valid, a fill of a new tag replaces the entry whose latest fill or hit is oldest. A lookup hit counts as a use.
- R9: `flush_all` held for one cycle invalidates every entry.
- R10: A match needs all 20 page-number bits equal. Pages that differ in any bit, low or high, do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush_all | input | 1 | Invalidate every entry |
| ctx_en | input | 1 | Context-enable control bit |
| ptbase_low | input | 12 | Low 12 bits of the page-table base register |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| rsp_valid | output | 1 | Lookup result valid, one cycle after request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_ro | output | 1 | Read-only flag of the hit entry |
| rsp_uc | output | 1 | Uncacheable flag of the hit entry |
| fill_valid | input | 1 | Insert a translation |
| fill_vaddr | input | 32 | Virtual address of the fill (offset bits ignored) |
| fill_ppn | input | 20 | Physical page number to store |
| fill_ro | input | 1 | Read-only flag to store |
| fill_uc | input | 1 | Uncacheable flag to store |

## Verification
The hardest condition to reach from the ports is eviction order in a full array whose stamps were reshuffled by hits and ignored duplicate fills. Only the sequence of later hits and misses shows which entry went. A directed pass fills all sixteen slots, touches one entry and inserts one more. A long random phase then works a pool of 24 pages and four context settings, so the array stays full and evictions, duplicate fills and cross-context lookups mix. Every lookup is compared against a bench model of the stamps.

// File: rtl/pcid_tlb.sv
module pcid_tlb #(
  parameter int ENTRIES   = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int SEQ_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush_all,
  input  logic                      ctx_en,
  input  logic [PAGE_BITS-1:0]      ptbase_low,
  input  logic                      lk_valid,
  input  logic [VA_W-1:0]           lk_vaddr,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [PA_W-1:0]           rsp_paddr,
  output logic                      rsp_ro,
  output logic                      rsp_uc,
  input  logic                      fill_valid,
  input  logic [VA_W-1:0]           fill_vaddr,
  input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
  input  logic                      fill_ro,
  input  logic                      fill_uc
);
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid_q;
  logic [VA_W-1:0]    key_q   [ENTRIES];
  logic [PPN_W-1:0]   ppn_q   [ENTRIES];
  logic               ro_q    [ENTRIES];
  logic               uc_q    [ENTRIES];
  logic [SEQ_W-1:0]   stamp_q [ENTRIES];
  logic [SEQ_W-1:0]   seq_q;

  logic [PAGE_BITS-1:0] ctx;
  logic [VA_W-1:0]      lk_key, fill_key;
  logic [ENTRIES-1:0]   lk_match, fill_match;
  logic                 lk_hit, fill_dup, do_ins;
  logic [IDX_W-1:0]     lk_idx, free_idx, old_idx, vic_idx;
  logic                 have_free;

  assign ctx      = ctx_en ? ptbase_low : '0;
  assign lk_key   = {lk_vaddr[VA_W-1:PAGE_BITS], ctx};
  assign fill_key = {fill_vaddr[VA_W-1:PAGE_BITS], ctx};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]   = valid_q[g] && (key_q[g] == lk_key);
    assign fill_match[g] = valid_q[g] && (key_q[g] == fill_key);
  end

  assign lk_hit   = lk_valid && (|lk_match);
  assign fill_dup = |fill_match;
  assign do_ins   = fill_valid && !fill_dup && !flush_all;

  always_comb begin
    lk_idx    = '0;
    free_idx  = '0;
    old_idx   = '0;
    have_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_idx = IDX_W'(i);
      if (!valid_q[i] && !have_free) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
    for (int i = 1; i < ENTRIES; i++)
      if (stamp_q[i] < stamp_q[old_idx]) old_idx = IDX_W'(i);
  end

  assign vic_idx = have_free ? free_idx : old_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= '0;
      seq_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_ro    <= 1'b0;
      rsp_uc    <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_paddr <= lk_hit ? {ppn_q[lk_idx], lk_vaddr[PAGE_BITS-1:0]} : '0;
      rsp_ro    <= lk_hit && ro_q[lk_idx];
      rsp_uc    <= lk_hit && uc_q[lk_idx];
      if (lk_hit) stamp_q[lk_idx] <= seq_q;
      if (flush_all) begin
        valid_q <= '0;
      end else if (do_ins) begin
        valid_q[vic_idx] <= 1'b1;
        key_q[vic_idx]   <= fill_key;
        ppn_q[vic_idx]   <= fill_ppn;
        ro_q[vic_idx]    <= fill_ro;
        uc_q[vic_idx]    <= fill_uc;
        stamp_q[vic_idx] <= lk_hit ? seq_q + 1'b1 : seq_q;
      end
      seq_q <= seq_q + SEQ_W'(lk_hit) + SEQ_W'(do_ins);
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);  // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);  // R2
  AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);  // R2
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_paddr == '0 && !rsp_ro && !rsp_uc));  // R3
  AST_KEY_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));  // R6
  AST_DUP_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_dup && !flush_all) |=> valid_q == $past(valid_q));  // R6
  AST_FREE_SLOT_USED: assert property (@(posedge clk) disable iff (rst)
    (do_ins && !(&valid_q)) |=> $countones(valid_q) == $countones($past(valid_q)) + 1);  // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> valid_q == '0);  // R9
endmodule

// File: tb/pcid_tlb_tb.sv
module pcid_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_all = 1'b0;
  logic        ctx_en = 1'b0;
  logic [11:0] ptbase_low = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        rsp_valid, rsp_hit, rsp_ro, rsp_uc;
  logic [31:0] rsp_paddr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_vaddr = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_ro = 1'b0, fill_uc = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcid_tlb dut_i (
    .clk(clk), .rst(rst), .flush_all(flush_all), .ctx_en(ctx_en), .ptbase_low(ptbase_low),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_paddr(rsp_paddr), .rsp_ro(rsp_ro), .rsp_uc(rsp_uc), .fill_valid(fill_valid),
    .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn), .fill_ro(fill_ro), .fill_uc(fill_uc));

  bit          m_valid [16];
  logic [31:0] m_key   [16];
  logic [19:0] m_ppn   [16];
  bit          m_ro    [16];
  bit          m_uc    [16];
  int unsigned m_stamp [16];
  int unsigned m_seq = 0;

  function automatic logic [31:0] mk_key(logic [31:0] va, logic en, logic [11:0] pb);
    return {va[31:12], en ? pb : 12'h000};
  endfunction

  function automatic int m_find(logic [31:0] key);
    for (int i = 0; i < 16; i++) if (m_valid[i] && m_key[i] == key) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int v = 0;
    for (int i = 0; i < 16; i++) if (!m_valid[i]) return i;
    for (int i = 1; i < 16; i++) if (m_stamp[i] < m_stamp[v]) v = i;
    return v;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic lookup(logic [31:0] va, logic en, logic [11:0] pb, string req);
    int idx = m_find(mk_key(va, en, pb));
    logic [31:0] exp_pa = (idx >= 0) ? {m_ppn[idx], va[11:0]} : 32'h0;
    bit eh = (idx >= 0);
    lk_valid = 1'b1; lk_vaddr = va; ctx_en = en; ptbase_low = pb;
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    chk("R2", "rsp_valid", 64'(rsp_valid), 64'(1));
    chk(req, "hit", 64'(rsp_hit), 64'(eh));
    chk(req, "paddr", 64'(rsp_paddr), 64'(exp_pa));
    chk(req, "ro/uc", 64'({rsp_ro, rsp_uc}), eh ? 64'({m_ro[idx], m_uc[idx]}) : 64'(0));
    if (eh) begin m_stamp[idx] = m_seq; m_seq++; end
  endtask

  task automatic fill(logic [31:0] va, logic en, logic [11:0] pb, logic [19:0] ppn, bit ro, bit uc);
    logic [31:0] key = mk_key(va, en, pb);
    if (m_find(key) < 0) begin
      int v = m_victim();
      m_valid[v] = 1'b1; m_key[v] = key; m_ppn[v] = ppn; m_ro[v] = ro; m_uc[v] = uc;
      m_stamp[v] = m_seq; m_seq++;
    end
    fill_valid = 1'b1; fill_vaddr = va; fill_ppn = ppn; fill_ro = ro; fill_uc = uc;
    ctx_en = en; ptbase_low = pb;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'(0));
  endtask

  task automatic flush();
    flush_all = 1'b1;
    @(posedge clk); @(negedge clk);
    flush_all = 1'b0;
    for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] pbs [4];
    pbs[0] = 12'h000; pbs[1] = 12'h001; pbs[2] = 12'h7FF; pbs[3] = 12'hFFF;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
    lookup(32'h0000_0123, 1'b0, 12'h0, "R1");
    lookup(32'hFFFF_F000, 1'b1, 12'hFFF, "R1");

    fill(32'h1234_5000, 1'b0, 12'h005, 20'hABCDE, 1'b1, 1'b0);
    lookup(32'h1234_5678, 1'b0, 12'h000, "R3");
    lookup(32'h1234_5FFF, 1'b0, 12'h3C3, "R4");
    lookup(32'h1234_5001, 1'b1, 12'h000, "R4");
    lookup(32'h1234_5001, 1'b1, 12'h005, "R4");
    fill(32'h1234_5ABC, 1'b1, 12'h005, 20'h11111, 1'b0, 1'b1);
    lookup(32'h1234_5010, 1'b1, 12'h005, "R5");
    lookup(32'h1234_5020, 1'b0, 12'h005, "R5");
    fill(32'h1234_5000, 1'b0, 12'h000, 20'h22222, 1'b0, 1'b1);
    lookup(32'h1234_5444, 1'b0, 12'h000, "R6");
    lookup(32'h1234_4678, 1'b0, 12'h000, "R10");
    lookup(32'h9234_5678, 1'b0, 12'h000, "R10");
    lookup(32'h1234_7678, 1'b0, 12'h000, "R10");

    flush();
    lookup(32'h1234_5678, 1'b0, 12'h000, "R9");
    lookup(32'h1234_5678, 1'b1, 12'h005, "R9");

    for (int i = 0; i < 16; i++)
      fill({20'h00100 + 20'(i), 12'h0}, 1'b0, 12'h0, 20'h50000 + 20'(i), i[0], i[1]);
    for (int i = 0; i < 16; i++)
      lookup({20'h00100 + 20'(i), 12'h0A0}, 1'b0, 12'h0, "R7");
    lookup(32'h0010_0004, 1'b0, 12'h0, "R8");
    fill(32'h0020_0000, 1'b0, 12'h0, 20'h77777, 1'b1, 1'b1);
    lookup(32'h0010_0008, 1'b0, 12'h0, "R8");
    lookup(32'h0010_1008, 1'b0, 12'h0, "R8");
    lookup(32'h0020_0FF0, 1'b0, 12'h0, "R8");
    fill(32'h0010_2000, 1'b0, 12'h0, 20'h0BEEF, 1'b0, 1'b0);
    fill(32'h0020_1000, 1'b0, 12'h0, 20'h66666, 1'b0, 1'b0);
    lookup(32'h0010_2000, 1'b0, 12'h0, "R6");
    lookup(32'h0010_3000, 1'b0, 12'h0, "R8");

    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom;
      logic [31:0] va = {20'h003A0 + 20'(r % 24), 12'($urandom)};
      logic en = r[8];
      logic [11:0] pb = pbs[r[10:9]];
      if (r[15:12] == 4'h0 && r[20:16] == 5'h0) flush();
      else if (r[11]) fill(va, en, pb, 20'($urandom), r[13], r[14]);
      else lookup(va, en, pb, "R8");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule